// File: doc/BRIEF.md
# Serial Status Readout Port

This block is the readback side of a synthesizer control interface. It is active only when the 4-bit mode selection field holds the serial output code. The host raises a chip enable and toggles a serial clock to read a 27-bit status word, one bit per clock, on a single open-drain data pin. The pin is modelled as a pull-low enable: a high enable means the pin is driven low, and a low enable means the pin is released to its pull-up.

While the chip enable is low, the same pin works as an event flag. The pin is released when the chip enable falls. It is later pulled low when the general-purpose input changes level or when a counter measurement reports completion. When both causes are seen, the counter is reported as the cause.

The chip enable, serial clock and general-purpose input are asynchronous to the system clock. Each passes through a two-flop synchronizer, and all edges are detected on the synchronized copies. The mode field and the counter-done strobe are taken to be in the system clock domain.

Top module: `status_readout_port`

## Requirements
- R1: When `mode_sel` is not 4'd3, `do_pull_low` stays 0 whatever happens on the other inputs, and no event is latched.
- R2: A rising edge of `ce_pin` captures `status_word`. Bit 0 then appears on the pin, with `do_pull_low` equal to the inverse of the bit, within a few system clocks and with no serial clock edge.
- R3: While `ce_pin` is high, each falling edge of `cl_pin` advances the readout by one bit. After k falling edges the pin shows `status_word[k]`, so bit 26, the last bit, appears after 26 falling edges (27 bit periods in all).
- R4: Falling edges of `cl_pin` beyond the 26th present ones, which leave the pin released (`do_pull_low` = 0).
- R5: A change of `status_word` after the capture has no effect on the bits being shifted out.
- R6: When `ce_pin` falls, the pin is released (`do_pull_low` = 0), even if the bit being shown was 0.
- R7: While `ce_pin` is low, a change of `gp_in` in either direction pulls the pin low and sets `evt_by_counter` to 0.
- R8: While `ce_pin` is low, a one-cycle `cnt_done` pulse pulls the pin low and sets `evt_by_counter` to 1.
- R9: Once a counter completion has been seen, the reported cause is the counter (`evt_by_counter` = 1), whether the completion came before or after an input change.
- R10: A rising edge of `ce_pin` clears a pending event, so the pin then shows the captured data rather than the event.
- R11: An input change or counter completion that occurs while `ce_pin` is high is not latched, and the pin is released after `ce_pin` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | Mode selection field; 3 enables this port |
| ce_pin | input | 1 | Chip enable from the host (asynchronous) |
| cl_pin | input | 1 | Serial clock from the host (asynchronous) |
| status_word | input | 27 | Parallel status word; bit 0 is shifted out first |
| gp_in | input | 1 | General-purpose input pin (asynchronous) |
| cnt_done | input | 1 | One-cycle counter-completion strobe |
| do_pull_low | output | 1 | Open-drain enable: 1 drives the data pin low |
| evt_by_counter | output | 1 | 1 when a pending event was caused by the counter |

## Verification
The hardest case to reach from the ports is the cause priority. An input change reaches the event logic several system clocks after the pin moves, because it must pass the synchronizer. A counter strobe arrives in the same cycle it is driven. The stimulus therefore creates one cause, lets it settle, and then adds the other in both orders, checking the reported cause each time. Clearing on the chip enable rising edge is exposed by raising the enable over a pending event with captured bit 0 set to 1, so a stale event would show as a low pin.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned SRP_WORD_W   = 27;
  localparam int unsigned SRP_MODE_W   = 4;
  localparam int unsigned SRP_SEL_CODE = 3;
  localparam int unsigned SRP_SYNC_LEN = 2;

  typedef enum logic {
    SRC_INPUT   = 1'b0,
    SRC_COUNTER = 1'b1
  } evt_src_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_shift_reg.sv
module srp_shift_reg #(
  parameter int unsigned WORD_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] shift_q,
  output logic              bit_out
);
  logic [WORD_W-1:0] shift_n;

  // Capture wins over shift; vacated positions fill with ones.
  always_comb begin
    shift_n = shift_q;
    if (load_en)       shift_n = load_word;
    else if (shift_en) shift_n = {1'b1, shift_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= shift_n;
  end

  assign bit_out = shift_q[0];
endmodule

// File: rtl/srp_event_latch.sv
module srp_event_latch
  import srp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     arm,
  input  logic     in_chg,
  input  logic     cnt_done,
  output logic     pend_q,
  output evt_src_e src_q
);
  logic     pend_n;
  evt_src_e src_n;

  always_comb begin
    pend_n = pend_q;
    src_n  = src_q;
    if (clr) begin
      pend_n = 1'b0;
      src_n  = SRC_INPUT;
    end else if (arm && (cnt_done || in_chg)) begin
      pend_n = 1'b1;
      if (cnt_done)     src_n = SRC_COUNTER;
      else if (!pend_q) src_n = SRC_INPUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      src_q  <= SRC_INPUT;
    end else begin
      pend_q <= pend_n;
      src_q  <= src_n;
    end
  end
endmodule

// File: rtl/status_readout_port.sv
module status_readout_port
  import srp_pkg::*;
#(
  parameter int unsigned WORD_W   = SRP_WORD_W,
  parameter int unsigned MODE_W   = SRP_MODE_W,
  parameter int unsigned SEL_CODE = SRP_SEL_CODE,
  parameter int unsigned SYNC_LEN = SRP_SYNC_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              ce_pin,
  input  logic              cl_pin,
  input  logic [WORD_W-1:0] status_word,
  input  logic              gp_in,
  input  logic              cnt_done,
  output logic              do_pull_low,
  output logic              evt_by_counter
);
  localparam int unsigned PIN_N = 3;
  localparam logic [MODE_W-1:0] SEL_VAL = MODE_W'(SEL_CODE);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [PIN_N-1:0] pin_raw, pin_s;
  assign pin_raw = {gp_in, cl_pin, ce_pin};

  srp_sync #(.W(PIN_N), .STAGES(SYNC_LEN)) sync_i (
    .clk(clk), .rst_n(rst_core_n), .d(pin_raw), .q(pin_s)
  );

  logic ce_s, cl_s, in_s;
  assign ce_s = pin_s[0];
  assign cl_s = pin_s[1];
  assign in_s = pin_s[2];

  // Delayed copies for edge detection.
  logic ce_d, cl_d, in_d;
  logic ce_d_n, cl_d_n, in_d_n;
  always_comb begin
    ce_d_n = ce_s;
    cl_d_n = cl_s;
    in_d_n = in_s;
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ce_d <= 1'b0;
      cl_d <= 1'b0;
      in_d <= 1'b0;
    end else begin
      ce_d <= ce_d_n;
      cl_d <= cl_d_n;
      in_d <= in_d_n;
    end
  end

  logic mode_on, ce_rise, ce_fall, cl_fall, in_chg;
  assign mode_on = (mode_sel == SEL_VAL);
  assign ce_rise = ce_s & ~ce_d;
  assign ce_fall = ~ce_s & ce_d;
  assign cl_fall = ~cl_s & cl_d;
  assign in_chg  = in_s ^ in_d;

  // Readout window flag.
  logic rd_act_q, rd_act_n;
  always_comb begin
    rd_act_n = rd_act_q;
    if (!mode_on || ce_fall)  rd_act_n = 1'b0;
    else if (ce_rise)         rd_act_n = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rd_act_q <= 1'b0;
    else             rd_act_q <= rd_act_n;
  end

  logic              load_en, shift_en, bit_out;
  logic [WORD_W-1:0] shift_q;
  assign load_en  = mode_on & ce_rise;
  assign shift_en = mode_on & rd_act_q & cl_fall;

  srp_shift_reg #(.WORD_W(WORD_W)) shreg_i (
    .clk(clk), .rst_n(rst_core_n), .load_en(load_en), .shift_en(shift_en),
    .load_word(status_word), .shift_q(shift_q), .bit_out(bit_out)
  );

  logic     evt_clr, evt_arm, evt_pend;
  evt_src_e evt_src;
  assign evt_clr = ~mode_on | ce_rise | ce_fall;
  assign evt_arm = mode_on & ~ce_s & ~rd_act_q;

  srp_event_latch evt_i (
    .clk(clk), .rst_n(rst_core_n), .clr(evt_clr), .arm(evt_arm),
    .in_chg(in_chg), .cnt_done(cnt_done), .pend_q(evt_pend), .src_q(evt_src)
  );

  assign do_pull_low    = mode_on & (rd_act_q ? ~bit_out : evt_pend);
  assign evt_by_counter = evt_pend & (evt_src == SRC_COUNTER);
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int unsigned WORD_W = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_on,
  input logic              ce_s,
  input logic              ce_rise,
  input logic              ce_fall,
  input logic              cl_fall,
  input logic              rd_act,
  input logic [WORD_W-1:0] shift_q,
  input logic [WORD_W-1:0] status_word,
  input logic              cnt_done,
  input logic              do_pull_low,
  input logic              evt_by_counter
);
  p_mode_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |-> !do_pull_low);

  p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && ce_rise) |=> (!mode_on || (do_pull_low == !$past(status_word[0]))));

  p_shift_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && rd_act && cl_fall && !ce_rise) |=>
      (shift_q == {1'b1, $past(shift_q[WORD_W-1:1])}));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> !do_pull_low);

  p_counter_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && !ce_s && !rd_act && !ce_fall && cnt_done) |=> evt_by_counter);

  p_cause_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && evt_by_counter) |-> do_pull_low);
endmodule

bind status_readout_port srp_checker #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_core_n), .mode_on(mode_on), .ce_s(ce_s),
  .ce_rise(ce_rise), .ce_fall(ce_fall), .cl_fall(cl_fall), .rd_act(rd_act_q),
  .shift_q(shift_q), .status_word(status_word), .cnt_done(cnt_done),
  .do_pull_low(do_pull_low), .evt_by_counter(evt_by_counter)
);

// File: tb/status_readout_port_tb.sv
module status_readout_port_tb_top;
  localparam int unsigned W      = 27;
  localparam int unsigned SETTLE = 6;
  localparam int unsigned NWORDS = 4;
  localparam logic [W-1:0] WORDS [NWORDS] = '{
    27'h0000001, 27'h7FFFFFE, 27'h5555555, 27'h2A3C5E1
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   mode_sel;
  logic         ce_pin, cl_pin, gp_in, cnt_done;
  logic [W-1:0] status_word;
  logic         do_pull_low, evt_by_counter;
  int           checks = 0;
  int           errors = 0;

  always #2 clk = ~clk;

  status_readout_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ce_pin(ce_pin),
    .cl_pin(cl_pin), .status_word(status_word), .gp_in(gp_in),
    .cnt_done(cnt_done), .do_pull_low(do_pull_low),
    .evt_by_counter(evt_by_counter)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_cnt();
    @(posedge clk); #1 cnt_done = 1'b1;
    @(posedge clk); #1 cnt_done = 1'b0;
    settle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 4'd3; ce_pin = 1'b0; cl_pin = 1'b0;
    gp_in = 1'b0; cnt_done = 1'b0; status_word = '0;
    settle(3);
    chk("reset do_pull_low", do_pull_low, 1'b0);
    chk("reset evt_by_counter", evt_by_counter, 1'b0);
    #1 rst_n = 1'b1;
    settle(4);

    // Table walk: R2 R3 R4 R5 R6
    for (int w = 0; w < NWORDS; w++) begin
      status_word = WORDS[w];
      #1 ce_pin = 1'b1;
      settle(SETTLE);
      chk("R2 first bit", do_pull_low, ~WORDS[w][0]);
      status_word = ~WORDS[w];  // R5: must not disturb the readout
      for (int k = 1; k <= W + 1; k++) begin
        #1 cl_pin = 1'b1; settle(SETTLE);
        #1 cl_pin = 1'b0; settle(SETTLE);
        if (k < W) chk("R3/R5 shifted bit", do_pull_low, ~WORDS[w][k]);
        else       chk("R4 extra fill", do_pull_low, 1'b0);
      end
      #1 ce_pin = 1'b0; settle(SETTLE);
      chk("R6 release after readout", do_pull_low, 1'b0);
    end

    // R6: release even while a 0 bit is shown
    status_word = '0;
    #1 ce_pin = 1'b1; settle(SETTLE);
    chk("R6 zero bit shown", do_pull_low, 1'b1);
    #1 ce_pin = 1'b0; settle(SETTLE);
    chk("R6 forced release", do_pull_low, 1'b0);

    // R7: input change, both directions
    #1 gp_in = 1'b1; settle(SETTLE);
    chk("R7 rise pulls low", do_pull_low, 1'b1);
    chk("R7 cause input", evt_by_counter, 1'b0);
    // R9: counter after input change takes over the cause
    pulse_cnt();
    chk("R9 counter after input", evt_by_counter, 1'b1);
    // R10: CE rise clears the event; bit 0 = 1 shows released
    status_word = 27'h0000001;
    #1 ce_pin = 1'b1; settle(SETTLE);
    chk("R10 cleared at CE rise", do_pull_low, 1'b0);
    #1 ce_pin = 1'b0; settle(SETTLE);
    chk("R10 released after CE fall", do_pull_low, 1'b0);
    chk("R10 cause cleared", evt_by_counter, 1'b0);
    #1 gp_in = 1'b0; settle(SETTLE);
    chk("R7 fall pulls low", do_pull_low, 1'b1);
    chk("R7 fall cause input", evt_by_counter, 1'b0);
    #1 ce_pin = 1'b1; settle(SETTLE);
    #1 ce_pin = 1'b0; settle(SETTLE);

    // R8 then R9: counter first, input change after keeps the counter cause
    pulse_cnt();
    chk("R8 counter pulls low", do_pull_low, 1'b1);
    chk("R8 cause counter", evt_by_counter, 1'b1);
    #1 gp_in = 1'b1; settle(SETTLE);
    chk("R9 input after counter", evt_by_counter, 1'b1);
    chk("R9 still low", do_pull_low, 1'b1);
    #1 ce_pin = 1'b1; settle(SETTLE);
    #1 ce_pin = 1'b0; settle(SETTLE);

    // R11: events while CE high are not latched
    status_word = '1;
    #1 ce_pin = 1'b1; settle(SETTLE);
    pulse_cnt();
    #1 gp_in = 1'b0; settle(SETTLE);
    chk("R11 readout unaffected", do_pull_low, 1'b0);
    #1 ce_pin = 1'b0; settle(SETTLE);
    chk("R11 nothing latched", do_pull_low, 1'b0);
    chk("R11 no cause", evt_by_counter, 1'b0);

    // R1: other mode codes keep the pin released
    mode_sel = 4'd5;
    status_word = '0;
    #1 ce_pin = 1'b1; settle(SETTLE);
    chk("R1 readout blocked", do_pull_low, 1'b0);
    #1 ce_pin = 1'b0; settle(SETTLE);
    pulse_cnt();
    #1 gp_in = 1'b1; settle(SETTLE);
    chk("R1 events blocked", do_pull_low, 1'b0);
    mode_sel = 4'd3; settle(2);
    chk("R1 nothing latched", do_pull_low, 1'b0);
    chk("R1 no cause", evt_by_counter, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule